// File: doc/BRIEF.md
# Byte-Lane Parity and Reorder Datapath

This block surrounds a 36-bit word store. The word is split into four lanes of 9 bits. On the store's write side, the block collects input transfers of 9, 18 or 36 bits and builds full words from them. If parity filling is turned on, it replaces the top bit of each lane with a parity bit calculated from the lower 8 bits of that lane, using the selected polarity. On the store's read side, the block accepts one stored word at a time and can mirror the order of its lanes to convert between endian conventions. It checks the parity of every lane against the selected polarity. It then sends the word out as a series of narrower pieces, one piece per cycle.

The write width and the read width each have their own control, and software may change either one at any time. On the write side, a new width value drops any word that is only partly built. On the read side, the width, the lane-swap control and the parity polarity are all captured at the moment a word is accepted. Changing them later therefore never splits a word that is already being sent.

Top module: `byte_lane_path`

## Requirements
- R1: A word is 36 bits holding four 9-bit lanes, with lane n in bits [9n+8:9n]. Width code 2'b00 selects 9-bit transfers, 2'b01 selects 18-bit transfers, and 2'b10 or 2'b11 selects 36-bit transfers. A narrow transfer uses the low bits of its data bus.
- R2: In 9-bit mode, four transfers fill lanes 0, 1, 2 and 3 in that order. In 18-bit mode, the first transfer fills lanes 0–1 and the second fills lanes 2–3. The finished word appears on st_wr_data with st_wr_valid high for exactly one cycle, starting at the clock edge that samples the final transfer.
- R3: In 36-bit write mode, every accepted transfer produces a word at the next clock edge.
- R4: If wr_width differs from its value in the previous cycle, any partly built word is discarded. A transfer made in that same cycle becomes the first transfer of a new word.
- R5: If par_gen_en is high in the cycle of a word's final transfer, bit 9n+8 of each lane is replaced. With par_even=0 (odd parity), every lane of the emitted word has an odd number of ones. With par_even=1, every lane has an even number of ones.
- R6: If par_gen_en is low, the packed word is emitted unchanged.
- R7: st_rd_ready is high when the read side is idle or is sending the last piece of its word. A word is taken when st_rd_valid and st_rd_ready are both high. rd_width, swap_en and par_even are captured at that edge.
- R8: If swap_en is captured high, lane n of the accepted word moves to lane 3−n before the word is unpacked.
- R9: Pieces leave in order starting from lane 0. They come one per cycle with no gaps and sit in the low bits of rd_data, with all unused upper bits at zero. The first piece is valid at the second clock edge after acceptance.
- R10: rd_par_err is high on every piece of a word if any lane of that word fails the captured polarity. Under odd parity, a lane fails if it has an even number of ones. Under even parity, a lane fails if it has an odd number of ones.
- R11: rd_par_err keeps its value in cycles when rd_valid is low. After reset, every output is zero except st_rd_ready, which is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_width | input | 2 | Write transfer width code |
| rd_width | input | 2 | Read piece width code |
| par_gen_en | input | 1 | Enables parity filling on the write side |
| par_even | input | 1 | Parity polarity: 0 is odd, 1 is even |
| swap_en | input | 1 | Mirrors lane order on read |
| wr_valid | input | 1 | Write transfer valid |
| wr_data | input | 36 | Write transfer data |
| st_wr_valid | output | 1 | Packed word valid toward the store |
| st_wr_data | output | 36 | Packed word toward the store |
| st_rd_valid | input | 1 | Stored word offered |
| st_rd_data | input | 36 | Stored word |
| st_rd_ready | output | 1 | Read side can take a word |
| rd_valid | output | 1 | Output piece valid |
| rd_data | output | 36 | Output piece, low-aligned |
| rd_par_err | output | 1 | Parity error flag for the current word |

## Verification
A wrong lane index on the write side shows up on the very next emitted word, either as lanes that are out of order or as a word emitted too early or too late. A stale index left over after a width change corrupts the first word built at the new width. On the read side, a wrong remaining-piece count or a mistake in the captured width shows up within one word time: there are missing or extra pieces, or the ready pulse comes at the wrong moment. A flag captured from the wrong word is wrong on that word's first piece. Parity-fill errors are visible in the emitted lane bits themselves.

// File: rtl/blp_pkg.sv
package blp_pkg;

    // Width codes for either port; any code above HALF selects a full word.
    localparam logic [1:0] WID_LANE = 2'b00;
    localparam logic [1:0] WID_HALF = 2'b01;
    localparam logic [1:0] WID_FULL = 2'b10;

    // Number of lanes carried by a single transfer at the given width code.
    function automatic int lanes_per_xfer(input logic [1:0] code, input int lanes);
        case (code)
            WID_LANE: return 1;
            WID_HALF: return lanes / 2;
            default:  return lanes;
        endcase
    endfunction

endpackage

// File: rtl/blp_par_fill.sv
module blp_par_fill #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              even_i,
    input  logic              fill_i,
    output logic [WORD_W-1:0] word_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-2:0] low;
        logic              pbit;
        assign low  = word_i[l*LANE_W +: LANE_W-1];
        // Odd mode: the full lane must have an odd count of ones.
        assign pbit = (^low) ^ ~even_i;
        assign word_o[l*LANE_W +: LANE_W] =
            fill_i ? {pbit, low} : word_i[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/blp_par_check.sv
module blp_par_check #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              even_i,
    output logic              err_o
);

    logic [LANES-1:0] lane_bad;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // A lane whose total parity equals the even flag is in error.
        assign lane_bad[l] = (^word_i[l*LANE_W +: LANE_W]) == even_i;
    end

    assign err_o = |lane_bad;

endmodule

// File: rtl/blp_pack.sv
module blp_pack #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        width_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              gen_en_i,
    input  logic              even_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic [1:0]        width;
        logic [IDX_W-1:0]  lane;
        logic [WORD_W-1:0] acc;
        logic              out_valid;
        logic [WORD_W-1:0] out_word;
    } pk_state_t;

    pk_state_t         s_q, s_d;
    logic              width_chg;
    int                base;
    int                lpt;
    logic              last_xfer;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] filled;

    // Place the incoming transfer into the lanes it covers.
    always_comb begin
        width_chg = (width_i != s_q.width);
        base      = width_chg ? 0 : int'(s_q.lane);
        lpt       = blp_pkg::lanes_per_xfer(width_i, LANES);
        last_xfer = (base + lpt) >= LANES;
        merged    = width_chg ? '0 : s_q.acc;
        for (int l = 0; l < LANES; l++) begin
            if (l >= base && l < base + lpt) begin
                merged[l*LANE_W +: LANE_W] = data_i[(l-base)*LANE_W +: LANE_W];
            end
        end
    end

    blp_par_fill #(.LANE_W(LANE_W), .LANES(LANES)) u_fill (
        .word_i (merged),
        .even_i (even_i),
        .fill_i (gen_en_i),
        .word_o (filled)
    );

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        if (width_chg) begin
            s_d.width = width_i;
            s_d.lane  = '0;
            s_d.acc   = '0;
        end
        if (valid_i) begin
            if (last_xfer) begin
                s_d.out_valid = 1'b1;
                s_d.out_word  = filled;
                s_d.lane      = '0;
                s_d.acc       = '0;
            end else begin
                s_d.acc  = merged;
                s_d.lane = IDX_W'(base + lpt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.width     <= blp_pkg::WID_FULL;
            s_q.lane      <= '0;
            s_q.acc       <= '0;
            s_q.out_valid <= 1'b0;
            s_q.out_word  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = s_q.out_valid;
    assign word_o  = s_q.out_word;

endmodule

// File: rtl/blp_unpack.sv
module blp_unpack #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES,
    localparam int REM_W  = $clog2(LANES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        width_i,
    input  logic              swap_i,
    input  logic              even_i,
    input  logic              load_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ready_o,
    output logic              valid_o,
    output logic [WORD_W-1:0] data_o,
    output logic              perr_o
);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [REM_W-1:0]  rem;
        logic [1:0]        wsel;
        logic              perr;
        logic              out_valid;
        logic [WORD_W-1:0] out_data;
        logic              out_perr;
    } up_state_t;

    up_state_t         s_q, s_d;
    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] piece;
    logic              chk_err;
    int                cur_bits;
    int                new_lpt;

    // Mirror the lane order end for end.
    for (genvar l = 0; l < LANES; l++) begin : g_swap
        assign swapped[l*LANE_W +: LANE_W] = word_i[(LANES-1-l)*LANE_W +: LANE_W];
    end

    blp_par_check #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
        .word_i (word_i),
        .even_i (even_i),
        .err_o  (chk_err)
    );

    always_comb begin
        cur_bits = blp_pkg::lanes_per_xfer(s_q.wsel, LANES) * LANE_W;
        new_lpt  = blp_pkg::lanes_per_xfer(width_i, LANES);
        for (int b = 0; b < WORD_W; b++) begin
            piece[b] = (b < cur_bits) ? s_q.hold[b] : 1'b0;
        end
        ready_o = s_q.rem <= REM_W'(1);
    end

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        if (s_q.rem != '0) begin
            s_d.out_valid = 1'b1;
            s_d.out_data  = piece;
            s_d.out_perr  = s_q.perr;
            s_d.hold      = s_q.hold >> cur_bits;
            s_d.rem       = s_q.rem - REM_W'(1);
        end
        if (load_valid_i && ready_o) begin
            s_d.hold = swap_i ? swapped : word_i;
            s_d.rem  = REM_W'(LANES / new_lpt);
            s_d.wsel = width_i;
            s_d.perr = chk_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.hold      <= '0;
            s_q.rem       <= '0;
            s_q.wsel      <= blp_pkg::WID_FULL;
            s_q.perr      <= 1'b0;
            s_q.out_valid <= 1'b0;
            s_q.out_data  <= '0;
            s_q.out_perr  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = s_q.out_valid;
    assign data_o  = s_q.out_data;
    assign perr_o  = s_q.out_perr;

endmodule

// File: rtl/byte_lane_path.sv
module byte_lane_path #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_width,
    input  logic [1:0]        rd_width,
    input  logic              par_gen_en,
    input  logic              par_even,
    input  logic              swap_en,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              st_wr_valid,
    output logic [WORD_W-1:0] st_wr_data,
    input  logic              st_rd_valid,
    input  logic [WORD_W-1:0] st_rd_data,
    output logic              st_rd_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_par_err
);

    blp_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .width_i  (wr_width),
        .valid_i  (wr_valid),
        .data_i   (wr_data),
        .gen_en_i (par_gen_en),
        .even_i   (par_even),
        .valid_o  (st_wr_valid),
        .word_o   (st_wr_data)
    );

    blp_unpack #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
        .clk          (clk),
        .rst_n        (rst_n),
        .width_i      (rd_width),
        .swap_i       (swap_en),
        .even_i       (par_even),
        .load_valid_i (st_rd_valid),
        .word_i       (st_rd_data),
        .ready_o      (st_rd_ready),
        .valid_o      (rd_valid),
        .data_o       (rd_data),
        .perr_o       (rd_par_err)
    );

endmodule

// File: rtl/blp_checker.sv
module blp_checker #(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        wr_width,
    input logic              par_gen_en,
    input logic              par_even,
    input logic              wr_valid,
    input logic              st_wr_valid,
    input logic [WORD_W-1:0] st_wr_data,
    input logic              st_rd_valid,
    input logic              st_rd_ready,
    input logic              rd_valid,
    input logic              rd_par_err
);

    logic [LANES-1:0] lane_x;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_x[l] = ^st_wr_data[l*LANE_W +: LANE_W];
    end

    a_r3_full_width_emits: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_valid) && $past(wr_width[1]) |-> st_wr_valid);

    a_r2_word_follows_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_valid |-> $past(wr_valid));

    a_r5_odd_fill: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_valid && $past(par_gen_en) && !$past(par_even) |-> (&lane_x));

    a_r5_even_fill: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_valid && $past(par_gen_en) && $past(par_even) |-> !(|lane_x));

    a_r9_first_piece_latency: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd_valid && st_rd_ready |=> ##1 rd_valid);

    a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_par_err));

endmodule

bind byte_lane_path blp_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_blp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_width    (wr_width),
    .par_gen_en  (par_gen_en),
    .par_even    (par_even),
    .wr_valid    (wr_valid),
    .st_wr_valid (st_wr_valid),
    .st_wr_data  (st_wr_data),
    .st_rd_valid (st_rd_valid),
    .st_rd_ready (st_rd_ready),
    .rd_valid    (rd_valid),
    .rd_par_err  (rd_par_err)
);

// File: tb/test_byte_lane_path.sv
module test_byte_lane_path;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int RAND_CYC   = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_width = 2'b10, rd_width = 2'b10;
    logic        par_gen_en = 1'b0, par_even = 1'b0, swap_en = 1'b0;
    logic        wr_valid = 1'b0, st_rd_valid = 1'b0;
    logic [35:0] wr_data = '0, st_rd_data = '0;
    logic        st_wr_valid, st_rd_ready, rd_valid, rd_par_err;
    logic [35:0] st_wr_data, rd_data;

    int checks = 0;
    int errors = 0;

    logic [35:0] wq[$];
    logic [35:0] rq[$];
    logic        pq[$];

    logic [1:0]  cur_ww = 2'b10, cur_rw = 2'b10;
    logic        cur_ge = 1'b0, cur_pe = 1'b0, cur_sw = 1'b0;
    logic [1:0]  m_width = 2'b10;
    int          m_lane = 0;
    logic [35:0] m_acc = '0;
    logic        last_perr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_lane_path i_byte_lane_path (
        .clk (clk), .rst_n (rst_n), .wr_width (wr_width), .rd_width (rd_width),
        .par_gen_en (par_gen_en), .par_even (par_even), .swap_en (swap_en),
        .wr_valid (wr_valid), .wr_data (wr_data),
        .st_wr_valid (st_wr_valid), .st_wr_data (st_wr_data),
        .st_rd_valid (st_rd_valid), .st_rd_data (st_rd_data), .st_rd_ready (st_rd_ready),
        .rd_valid (rd_valid), .rd_data (rd_data), .rd_par_err (rd_par_err)
    );

    function automatic int lpt(input logic [1:0] w);
        return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [35:0] fill(input logic [35:0] w, input logic even);
        logic [35:0] r = w;
        for (int l = 0; l < 4; l++) r[l*9+8] = (^w[l*9 +: 8]) ^ ~even;
        return r;
    endfunction

    function automatic logic bad(input logic [35:0] w, input logic even);
        logic e = 1'b0;
        for (int l = 0; l < 4; l++) if ((^w[l*9 +: 9]) == even) e = 1'b1;
        return e;
    endfunction

    function automatic logic [35:0] swap(input logic [35:0] w);
        logic [35:0] r;
        for (int l = 0; l < 4; l++) r[l*9 +: 9] = w[(3-l)*9 +: 9];
        return r;
    endfunction

    function automatic logic [35:0] rnd36();
        logic [63:0] t = {$urandom, $urandom};
        return t[35:0];
    endfunction

    task automatic chk(input logic ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_wr(input logic wv, input logic [35:0] wd);
        if (cur_ww != m_width) begin   // R4 discard on width change
            m_lane = 0; m_acc = '0; m_width = cur_ww;
        end
        if (wv) begin
            for (int k = 0; k < lpt(cur_ww); k++) m_acc[(m_lane+k)*9 +: 9] = wd[k*9 +: 9];
            m_lane += lpt(cur_ww);
            if (m_lane >= 4) begin
                wq.push_back(cur_ge ? fill(m_acc, cur_pe) : m_acc);
                m_lane = 0; m_acc = '0;
            end
        end
    endtask

    task automatic model_rd(input logic [35:0] w);
        logic [35:0] v = cur_sw ? swap(w) : w;
        logic        e = bad(w, cur_pe);
        int          n = lpt(cur_rw);
        for (int k = 0; k < 4 / n; k++) begin
            logic [35:0] p = (v >> (k*n*9)) & ((36'h1 << (n*9)) - 36'h1);
            if (n == 4) p = v;
            rq.push_back(p);
            pq.push_back(e);
        end
    endtask

    task automatic monitor();
        logic [35:0] e;
        logic        ep;
        if (st_wr_valid) begin
            if (wq.size() == 0) chk(1'b0, "R2 unexpected word", st_wr_data, '0);
            else begin
                e = wq.pop_front();
                chk(st_wr_data == e, "R2/R5/R6 packed word", st_wr_data, e);
            end
        end
        if (rd_valid) begin
            if (rq.size() == 0) chk(1'b0, "R9 unexpected piece", rd_data, '0);
            else begin
                e = rq.pop_front(); ep = pq.pop_front();
                chk(rd_data == e, "R8/R9 read piece", rd_data, e);
                chk(rd_par_err == ep, "R10 parity flag", {35'b0, rd_par_err}, {35'b0, ep});
                last_perr = ep;
            end
        end else begin
            chk(rd_par_err == last_perr, "R11 flag hold", {35'b0, rd_par_err}, {35'b0, last_perr});
        end
    endtask

    task automatic step(input logic wv, input logic [35:0] wd, input logic rv, input logic [35:0] rw);
        wr_width = cur_ww; rd_width = cur_rw; par_gen_en = cur_ge;
        par_even = cur_pe; swap_en = cur_sw;
        wr_valid = wv; wr_data = wd; st_rd_valid = rv; st_rd_data = rw;
        model_wr(wv, wd);
        if (rv && st_rd_ready) model_rd(rw);   // R7 acceptance
        @(negedge clk);
        monitor();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!st_wr_valid && st_wr_data == '0, "R11 reset write side", st_wr_data, '0);
        chk(!rd_valid && rd_data == '0 && !rd_par_err, "R11 reset read side", rd_data, '0);
        chk(st_rd_ready, "R11 reset ready", {35'b0, st_rd_ready}, 36'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R5: full-width zero word with odd fill, emitted one edge later
        cur_ge = 1'b1; cur_pe = 1'b0;
        step(1'b1, 36'h0, 1'b0, '0);
        chk(st_wr_valid && st_wr_data == 36'h804020100, "R3 R5 odd fill timing", st_wr_data, 36'h804020100);
        cur_ge = 1'b0;
        step(1'b0, '0, 1'b0, '0);

        // R4: two 9-bit transfers then switch to 18-bit
        cur_ww = 2'b00;
        step(1'b1, 36'h1AA, 1'b0, '0);
        step(1'b1, 36'h155, 1'b0, '0);
        cur_ww = 2'b01;
        step(1'b1, 36'h00001, 1'b0, '0);
        step(1'b1, 36'h00002, 1'b0, '0);
        chk(st_wr_valid && st_wr_data == 36'h000080001, "R4 discard partial", st_wr_data, 36'h000080001);

        // R1 code 11 behaves as full width; R6 pass-through
        cur_ww = 2'b11;
        step(1'b1, 36'hFEDCBA987, 1'b0, '0);
        chk(st_wr_valid && st_wr_data == 36'hFEDCBA987, "R1 R6 code 11 full", st_wr_data, 36'hFEDCBA987);

        // R8/R9: swapped 9-bit unpack
        cur_rw = 2'b00; cur_sw = 1'b1;
        step(1'b0, '0, 1'b1, 36'h040100401);
        chk(!rd_valid, "R9 not yet valid", {35'b0, rd_valid}, '0);
        step(1'b0, '0, 1'b0, '0);
        chk(rd_valid, "R9 first piece latency", {35'b0, rd_valid}, 36'h1);
        repeat (4) step(1'b0, '0, 1'b0, '0);

        // R10: even polarity, one bad lane, 18-bit pieces
        cur_rw = 2'b01; cur_sw = 1'b0; cur_pe = 1'b1;
        step(1'b0, '0, 1'b1, fill(36'h123456789, 1'b1) ^ 36'h000040000);
        repeat (4) step(1'b0, '0, 1'b0, '0);

        // Random phase
        void'($urandom(32'd1234));
        for (int c = 0; c < RAND_CYC; c++) begin
            logic wv, rv;
            logic [35:0] rw;
            if ($urandom_range(19) == 0) cur_ww = 2'($urandom_range(3));
            if ($urandom_range(19) == 0) cur_rw = 2'($urandom_range(3));
            if ($urandom_range(29) == 0) cur_ge = ~cur_ge;
            if ($urandom_range(59) == 0) cur_pe = ~cur_pe;
            if ($urandom_range(9) == 0)  cur_sw = ~cur_sw;
            wv = ($urandom_range(9) < 7);
            rv = ($urandom_range(1) == 0);
            rw = ($urandom_range(3) == 0) ? rnd36() : fill(rnd36(), cur_pe);
            step(wv, rnd36(), rv, rw);
        end
        repeat (10) step(1'b0, '0, 1'b0, '0);
        chk(wq.size() == 0, "R2 all words emitted", 36'(wq.size()), '0);
        chk(rq.size() == 0, "R9 all pieces emitted", 36'(rq.size()), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule